// File: doc/BRIEF.md
# Saturating Two-Digit Detection Counter with Seven-Segment Output

This block counts one-cycle detection pulses from an upstream serial pattern detector. It drives two seven-segment digit patterns, tens and units, that show the running total in decimal. The total is kept directly as binary-coded decimal digits, so no binary-to-decimal conversion step is needed before the segment decode.

The display does not wrap. When the total would go past the largest two-digit value, both digits switch to a dash. They keep showing the dash until the block is reset, however many more pulses arrive. Both segment outputs come from flops. They change on the same clock edge that samples the detect pulse, so the display lags the pulse by exactly one edge.

Top module: `det_count_display`

## Requirements
- R1: A clock edge with `rst_n` low clears the count and the overflow state. After it, both segment outputs show the digit 0 (`7'h3F`).
- R2: Each clock edge that samples `det_i` high adds one to the count. An edge that samples `det_i` low leaves both outputs unchanged.
- R3: A count from 0 to 99 is shown as two decimal digits, with the tens on `seg_tens_o` and the units on `seg_units_o`. Below 10, the tens output shows a 0.
- R4: Segments are active high. Bit 0 is segment a and bit 6 is segment g (bit order g,f,e,d,c,b,a from MSB down). The digits 0 to 9 encode as 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R5: When the units digit is 9 and a pulse arrives, the units digit goes to 0 and the tens digit increases by one.
- R6: The pulse that would take the count past 99 makes both outputs show a dash. A dash is segment g alone (`7'h40`).
- R7: The overflow indication is sticky. Further pulses leave both outputs at the dash until a reset.
- R8: The outputs keep their old value until the clock edge that samples a pulse, and show the new count right after that edge.
- R9: If reset and a detect pulse occur on the same edge, reset wins and the outputs show 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| det_i | input | 1 | One-cycle detection pulse |
| seg_tens_o | output | 7 | Tens digit segments, bit 6 = g ... bit 0 = a, active high |
| seg_units_o | output | 7 | Units digit segments, bit 6 = g ... bit 0 = a, active high |

## Verification
A wrong digit or a wrong overflow flag inside the counter shows up at the segment outputs on the same edge it is created, because the output flops are loaded from the counter's next state. A lost carry from units to tens shows as a wrong tens pattern at the 9-to-10 and 99 boundaries. A missed or early overflow shows as a number where a dash should be, or a dash where 99 should be. A flag that fails to stick, or a counter that keeps moving after overflow, only becomes visible when the next pulse or reset arrives. For that reason the bench sends pulses after the overflow and then resets. It also walks the units digit through every value, so that each segment pattern reaches the ports.

// File: rtl/dcd_pkg.sv
// Shared constants and the digit-to-segment table for the detection counter.
// Assumes active-high segments, bit 6 = g down to bit 0 = a.
package dcd_pkg;
    localparam int SEG_W  = 7;
    localparam int BCD_W  = 4;
    localparam int NDIG   = 2;

    localparam logic [SEG_W-1:0] SEG_DASH = 7'b100_0000;
    localparam logic [BCD_W-1:0] DIG_MAX  = BCD_W'(9);

    // Map one decimal digit onto its segment pattern; out-of-range digits go blank.
    function automatic logic [SEG_W-1:0] seg_of(input logic [BCD_W-1:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'b011_1111;
            4'd1:    s = 7'b000_0110;
            4'd2:    s = 7'b101_1011;
            4'd3:    s = 7'b100_1111;
            4'd4:    s = 7'b110_0110;
            4'd5:    s = 7'b110_1101;
            4'd6:    s = 7'b111_1101;
            4'd7:    s = 7'b000_0111;
            4'd8:    s = 7'b111_1111;
            4'd9:    s = 7'b110_1111;
            default: s = '0;
        endcase
        return s;
    endfunction

    localparam logic [SEG_W-1:0] SEG_ZERO = 7'b011_1111;
endpackage

// File: rtl/dcd_bcd_counter.sv
// Decimal counter of NDIG BCD digits with a sticky overflow flag.
// Digit i+1 steps when digit i wraps 9 -> 0. A carry out of the top digit
// sets the flag, and the flag freezes the count until reset.
// Both next-state and current-state values are exported so that a
// following register stage can align with the counter's own edge.
// Assumes: rst_n is synchronous, active low; inc_i is a one-cycle pulse.
module dcd_bcd_counter #(
    parameter int NDIG  = 2,
    parameter int BCD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [BCD_W-1:0] dig_d_o [NDIG],
    output logic [BCD_W-1:0] dig_q_o [NDIG],
    output logic             ovf_d_o,
    output logic             ovf_q_o
);
    localparam logic [BCD_W-1:0] TOP = BCD_W'(9);

    logic [NDIG:0]    carry;
    logic [BCD_W-1:0] dig_d [NDIG];
    logic [BCD_W-1:0] dig_q [NDIG];
    logic             ovf_d;
    logic             ovf_q;

    // Increments enter the chain only while the flag is clear.
    assign carry[0] = inc_i & ~ovf_q;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        // Next value of digit i: hold, step, or wrap to zero on carry-in.
        always_comb begin
            dig_d[i] = dig_q[i];
            if (carry[i]) begin
                dig_d[i] = (dig_q[i] == TOP) ? '0 : dig_q[i] + 1'b1;
            end
        end

        // Carry to the next digit when this one wraps.
        assign carry[i+1] = carry[i] & (dig_q[i] == TOP);

        // Digit storage with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) dig_q[i] <= '0;
            else        dig_q[i] <= dig_d[i];
        end

        // R5: a stored digit never leaves the decimal range.
        a_r5_digit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q[i] <= TOP);

        assign dig_d_o[i] = dig_d[i];
        assign dig_q_o[i] = dig_q[i];
    end

    // Overflow flag is set by carry out of the top digit and only cleared by reset.
    assign ovf_d = ovf_q | carry[NDIG];

    // Flag storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign ovf_d_o = ovf_d;
    assign ovf_q_o = ovf_q;

    // R7: once set the flag stays set.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R7: counter frozen after overflow.
    a_r7_frozen_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> $stable(dig_q[0]));

    // R6: the flag can only rise on an edge that saw a pulse.
    a_r6_ovf_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_q && !inc_i) |=> !ovf_q);

    // R2: no pulse, no change of the low digit.
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(dig_q[0]));

    // R2: a pulse below 9 in the low digit steps it by one.
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ovf_q && dig_q[0] != TOP) |=> (dig_q[0] == BCD_W'($past(dig_q[0]) + 1'b1)));
endmodule

// File: rtl/dcd_seg_enc.sv
// Combinational decoder for one digit position: shows the digit's segment
// pattern, or a dash when dash_i is set.
// Assumes the digit is in 0..9 whenever dash_i is low.
module dcd_seg_enc
    import dcd_pkg::*;
(
    input  logic [BCD_W-1:0] digit_i,
    input  logic             dash_i,
    output logic [SEG_W-1:0] seg_o
);
    // Choose dash or digit pattern.
    always_comb begin
        seg_o = dash_i ? SEG_DASH : seg_of(digit_i);
    end
endmodule

// File: rtl/det_count_display.sv
// Top level: counts detection pulses in BCD and drives two registered
// seven-segment digit patterns. Past 99 both digits show a dash until reset.
// The output flops load the encoding of the counter's next state, so the
// display moves on the same edge that samples a pulse.
// Assumes: synchronous active-low reset; det_i is one cycle wide per event.
module det_count_display
    import dcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    output logic [SEG_W-1:0] seg_tens_o,
    output logic [SEG_W-1:0] seg_units_o
);
    logic [BCD_W-1:0] dig_d [NDIG];
    logic [BCD_W-1:0] dig_q [NDIG];
    logic             ovf_d;
    logic             ovf_q;
    logic [SEG_W-1:0] seg_d [NDIG];
    logic [SEG_W-1:0] seg_q [NDIG];

    dcd_bcd_counter #(
        .NDIG  (NDIG),
        .BCD_W (BCD_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (det_i),
        .dig_d_o (dig_d),
        .dig_q_o (dig_q),
        .ovf_d_o (ovf_d),
        .ovf_q_o (ovf_q)
    );

    for (genvar i = 0; i < NDIG; i++) begin : g_pos
        dcd_seg_enc u_enc (
            .digit_i (dig_d[i]),
            .dash_i  (ovf_d),
            .seg_o   (seg_d[i])
        );

        // Output register per digit, reset to the zero pattern.
        always_ff @(posedge clk) begin
            if (!rst_n) seg_q[i] <= SEG_ZERO;
            else        seg_q[i] <= seg_d[i];
        end
    end

    assign seg_units_o = seg_q[0];
    assign seg_tens_o  = seg_q[NDIG-1];

    // R1: a reset edge leaves both digits at zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (seg_units_o == SEG_ZERO && seg_tens_o == SEG_ZERO));

    // R6: overflow flag and dash display agree.
    a_r6_dash_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (seg_units_o == SEG_DASH && seg_tens_o == SEG_DASH));

    // R3: without overflow the outputs show the stored digits.
    a_r3_shows_digits: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_q |-> (seg_units_o == seg_of(dig_q[0]) && seg_tens_o == seg_of(dig_q[NDIG-1])));

    // R4: a numeric display never lights segment g alone.
    a_r4_no_dash_without_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_q |-> (seg_units_o != SEG_DASH));
endmodule

// File: tb/det_count_display_tb.sv
// Directed bench: one task per scenario, each checking its own results
// against a reference count kept in the bench.
module det_count_display_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_i = 1'b0;
    logic [6:0] seg_tens_o;
    logic [6:0] seg_units_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit exp_ovf = 1'b0;

    det_count_display u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_i       (det_i),
        .seg_tens_o  (seg_tens_o),
        .seg_units_o (seg_units_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Segment table from R4, bit 6 = g .. bit 0 = a.
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what);
        logic [6:0] et, eu;
        et = exp_ovf ? 7'h40 : pat(exp_cnt / 10);
        eu = exp_ovf ? 7'h40 : pat(exp_cnt % 10);
        checks++;
        if (seg_tens_o !== et || seg_units_o !== eu) begin
            errors++;
            $display("FAIL %s %s: tens=%h units=%h expected tens=%h units=%h",
                     req, what, seg_tens_o, seg_units_o, et, eu);
        end
    endtask

    // Reference model step for one sampled pulse.
    task automatic model_pulse();
        if (!exp_ovf) begin
            if (exp_cnt == 99) exp_ovf = 1'b1;
            else               exp_cnt++;
        end
    endtask

    // Drive det_i for n cycles, changed and sampled on falling edges.
    task automatic drive(input bit v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            det_i = v;
            @(negedge clk);
            det_i = 1'b0;
            if (v) model_pulse();
        end
    endtask

    // Back-to-back pulses held high for n edges.
    task automatic burst(input int n);
        @(negedge clk);
        det_i = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            model_pulse();
        end
        det_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        det_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        exp_ovf = 1'b0;
        check("R1", "after reset");
    endtask

    task automatic t_latency();
        @(negedge clk);
        det_i = 1'b1;
        #(CLK_PERIOD/2 - 1);
        check("R8", "before sampling edge");
        @(negedge clk);
        det_i = 1'b0;
        model_pulse();
        check("R8", "after sampling edge");
    endtask

    task automatic t_idle();
        drive(1'b0, 6);
        check("R2", "idle cycles hold count");
    endtask

    task automatic t_walk();
        // Step one at a time through 2..12 to see every units pattern.
        for (int k = 0; k < 11; k++) begin
            drive(1'b1, 1);
            if (exp_cnt < 10) check("R3", "leading zero tens");
            else if (exp_cnt == 10) check("R5", "units wrap carries into tens");
            else check("R4", "digit pattern");
            drive(1'b0, 1);
        end
    endtask

    task automatic t_burst();
        burst(7);
        check("R2", "back-to-back pulses");
    endtask

    task automatic t_overflow();
        burst(99 - exp_cnt);
        check("R3", "count 99 shown as number");
        drive(1'b1, 1);
        check("R6", "dash after passing 99");
        burst(15);
        check("R7", "dash holds under more pulses");
        drive(1'b0, 4);
        check("R7", "dash holds when idle");
        t_reset();
        check("R7", "reset clears overflow");
        drive(1'b1, 3);
        check("R2", "counts again after overflow reset");
    endtask

    task automatic t_reset_priority();
        @(negedge clk);
        rst_n = 1'b0;
        det_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        det_i = 1'b0;
        exp_cnt = 0;
        exp_ovf = 1'b0;
        check("R9", "reset beats simultaneous pulse");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_idle();
        t_walk();
        t_burst();
        t_idle();
        t_overflow();
        t_reset_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule